// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static memory that is 36 bits wide and split into four 9-bit byte lanes. Every control input, the address and the write data are captured on the rising clock edge, and read data leaves through a second register stage. Its depth is set by an address-width parameter, so simulation can use a small array. A burst starts when either of two active-low strobes loads an address. The first strobe always loads. The second loads only while the active-low enable is low. After the load, a 2-bit counter can step through the four words that share the upper address bits. A static mode input chooses between sequential and XOR-style ordering.

Each rising edge during an active burst is one operation at the current burst address. That operation is a write when any byte lane is enabled, and a read when none is. Write enables follow three levels of precedence: a global write first, then a gate for the per-lane enables, then the per-lane enables themselves. Read data comes out on a separate data port together with a valid flag. An asynchronous output enable masks that flag. The asynchronous active-low reset is released in step with the clock.

Top module: `sbsram_core`

## Requirements
- R1: An address loads at a rising edge when `strb_ctl_n` is low, or when `strb_cpu_n` and `ce_n` are both low. When `strb_ctl_n` is high and `ce_n` is high, a low `strb_cpu_n` has no effect and the burst goes on from its current address.
- R2: When both strobes are low at the same edge, the address on `addr` is loaded and the burst counter restarts at zero, even if `adv_n` is low.
- R3: If no load occurs at an edge, a low `adv_n` steps the burst counter by one (modulo 4). A high `adv_n` holds it, so the same address is accessed again.
- R4: With `order_il` low, a burst that starts at low offset s visits the offsets s, s+1, s+2, s+3 modulo 4, and `addr[AW-1:2]` stays fixed.
- R5: With `order_il` high, a burst that starts at low offset s visits the offsets s^0, s^1, s^2, s^3, and the upper address bits stay fixed.
- R6: When `gw_n` is low during an active operation, all four lanes are written from `din`, whatever `bwgate_n` and `bwb_n` hold. Lane i is bits [9i+8:9i].
- R7: When `gw_n` is high and `bwgate_n` is low, each lane i whose `bwb_n[i]` is low is written, and the other lanes keep their contents. When `bwgate_n` is high, `bwb_n` writes nothing and the operation is a read.
- R8: The memory is selected only when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0 all hold. A load while it is not selected ends the burst. No later write changes the array and no later read produces valid data until a selected load.
- R9: For an operation at rising edge k, read data appears on `dout` with `dout_vld` high after edge k+1. A write becomes visible to reads at edge k+1 or later.
- R10: A high `oe_n` drives `dout_vld` low at once, without waiting for a clock. An output slot that belongs to a write operation has `dout_vld` low.
- R11: While reset is active, and after its synchronous release until the first read, no burst is active and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Address loaded by a strobe |
| strb_ctl_n | input | 1 | Controller address strobe, active low, always honoured |
| strb_cpu_n | input | 1 | Processor address strobe, active low, honoured only with `ce_n` low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 1 = interleaved, 0 = linear (static) |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwgate_n | input | 1 | Gate for the per-lane enables, active low |
| bwb_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Registered read data |
| dout_vld | output | 1 | Read data valid, masked by `oe_n` |

## Verification
A wrong burst counter or a wrong order selection shows up as data read from the wrong word. That difference is visible at `dout` one edge after the operation, on the first step that goes wrong. A faulty write-enable decode leaves the wrong lanes behind, so the error appears only when that address is read back. The bench therefore writes to every location first and then compares each read against a reference array. A selection or deselection error shows up as an unexpected level of `dout_vld` exactly two edges after the load that caused it.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Low-offset sequence inside a four-word burst.
  function automatic logic [1:0] burst_ofs(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       il);
    burst_ofs = il ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbsram_addr.sv
module sbsram_addr
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          strb_ctl_n,
  input  logic          strb_cpu_n,
  input  logic          ce_n,
  input  logic          sel,
  input  logic          adv_n,
  input  logic          order_il,
  output logic          nxt_act,
  output logic          act_q,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          act_d, ld, stp, st_en;

  assign ld    = ~strb_ctl_n | (~strb_cpu_n & ~ce_n);
  assign stp   = ~ld & ~adv_n & act_q;
  assign st_en = ld | stp;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (ld) begin
      base_d = addr;
      cnt_d  = 2'd0;
      act_d  = sel;
    end else if (stp) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else if (st_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign nxt_act  = st_en ? act_d : act_q;
  assign cur_addr = {base_q[AW-1:2], burst_ofs(base_q[1:0], cnt_q, order_il)};
endmodule

// File: rtl/sbsram_wrctl.sv
module sbsram_wrctl
  import sbsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nxt_act,
  input  logic              gw_n,
  input  logic              bwgate_n,
  input  logic [LANES-1:0]  bwb_n,
  input  logic [WORD_W-1:0] din,
  output logic [LANES-1:0]  wmask_q,
  output logic              rd_q,
  output logic [WORD_W-1:0] din_q
);
  logic [LANES-1:0] mask_raw, mask_d;
  logic             rd_d;

  // Precedence: global write, then the gate, then the lane enables.
  always_comb begin
    if (!gw_n)          mask_raw = '1;
    else if (!bwgate_n) mask_raw = ~bwb_n;
    else                mask_raw = '0;
    mask_d = nxt_act ? mask_raw : '0;
    rd_d   = nxt_act & (mask_raw == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      wmask_q <= mask_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (|mask_d) din_q <= din;
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     op_addr,
  input  logic [LANES-1:0]  wmask,
  input  logic              rd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata_q,
  output logic              vld_q
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] word_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wmask[g]) mem[op_addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign word_rd[g*LANE_W +: LANE_W] = mem[op_addr];
  end

  always_ff @(posedge clk) begin
    if (rd) rdata_q <= word_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd;
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              strb_ctl_n,
  input  logic              strb_cpu_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              gw_n,
  input  logic              bwgate_n,
  input  logic [3:0]        bwb_n,
  input  logic              oe_n,
  input  logic [35:0]       din,
  output logic [35:0]       dout,
  output logic              dout_vld
);
  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic              sel, nxt_act, act_q, rd_q, vld_q;
  logic [AW-1:0]     cur_addr;
  logic [LANES-1:0]  wmask_q;
  logic [WORD_W-1:0] din_q, rdata_q;

  // Reset asserts at once, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign sel = ~ce_n & cs_hi & ~cs_lo_n;

  sbsram_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .addr(addr),
    .strb_ctl_n(strb_ctl_n), .strb_cpu_n(strb_cpu_n), .ce_n(ce_n),
    .sel(sel), .adv_n(adv_n), .order_il(order_il),
    .nxt_act(nxt_act), .act_q(act_q), .cur_addr(cur_addr)
  );

  sbsram_wrctl u_wrctl (
    .clk(clk), .rst_n(rst_n_s), .nxt_act(nxt_act),
    .gw_n(gw_n), .bwgate_n(bwgate_n), .bwb_n(bwb_n), .din(din),
    .wmask_q(wmask_q), .rd_q(rd_q), .din_q(din_q)
  );

  sbsram_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n_s), .op_addr(cur_addr),
    .wmask(wmask_q), .rd(rd_q), .wdata(din_q),
    .rdata_q(rdata_q), .vld_q(vld_q)
  );

  assign dout     = rdata_q;
  assign dout_vld = vld_q & ~oe_n;
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic [AW-1:0] addr,
  input logic          strb_ctl_n,
  input logic          strb_cpu_n,
  input logic          adv_n,
  input logic          order_il,
  input logic          ce_n,
  input logic          cs_hi,
  input logic          cs_lo_n,
  input logic          gw_n,
  input logic          dout_vld,
  input logic          act_q,
  input logic [AW-1:0] cur_addr
);
  logic sel_c, ld_c;
  assign sel_c = ~ce_n & cs_hi & ~cs_lo_n;
  assign ld_c  = ~strb_ctl_n | (~strb_cpu_n & ~ce_n);

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !strb_ctl_n |=> cur_addr == $past(addr)); // R2

  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (strb_ctl_n && !strb_cpu_n && !ce_n) |=> cur_addr == $past(addr)); // R1

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ld_c && adv_n) |=> $stable(cur_addr)); // R3

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ld_c && !adv_n && act_q && !order_il)
      |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1); // R4

  AST_IL_UPPER: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ld_c && !adv_n && act_q && order_il)
      |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R5

  AST_DESEL_VLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ld_c && !sel_c) |=> ##1 !dout_vld); // R8

  AST_WRITE_VLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ld_c && sel_c && !gw_n) |=> ##1 !dout_vld); // R10
endmodule

bind sbsram_core sbsram_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .addr(addr),
  .strb_ctl_n(strb_ctl_n), .strb_cpu_n(strb_cpu_n), .adv_n(adv_n),
  .order_il(order_il), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
  .gw_n(gw_n), .dout_vld(dout_vld), .act_q(act_q), .cur_addr(cur_addr)
);

// File: tb/sbsram_core_test.sv
`timescale 1ns/1ps
module sbsram_core_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          strb_ctl_n, strb_cpu_n, adv_n, order_il;
  logic          ce_n, cs_hi, cs_lo_n, gw_n, bwgate_n, oe_n;
  logic [3:0]    bwb_n;
  logic [35:0]   din, dout;
  logic          dout_vld;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  logic [35:0]   ref_mem [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_act;
  logic [3:0]    p_mask;
  logic          p_rd;
  logic [AW-1:0] p_addr;
  logic [35:0]   p_din;
  logic          e_vld;
  logic [35:0]   e_data;

  always #2.5 clk = ~clk;

  sbsram_core #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_ctl_n(strb_ctl_n),
    .strb_cpu_n(strb_cpu_n), .adv_n(adv_n), .order_il(order_il),
    .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gw_n(gw_n),
    .bwgate_n(bwgate_n), .bwb_n(bwb_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [AW-1:0] eff_addr(input logic [AW-1:0] b,
                                             input logic [1:0] c,
                                             input logic il);
    logic [1:0] o;
    o = il ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], o};
  endfunction

  function automatic logic [3:0] lane_mask(input logic g, input logic gate,
                                           input logic [3:0] bw);
    if (!g) return 4'hF;
    if (!gate) return ~bw;
    return 4'h0;
  endfunction

  task automatic idle();
    strb_ctl_n = 1; strb_cpu_n = 1; adv_n = 1;
    ce_n = 0; cs_hi = 1; cs_lo_n = 0;
    gw_n = 1; bwgate_n = 1; bwb_n = 4'hF; oe_n = 0;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One clock: model the edge from the requirements, then check at the falling edge.
  task automatic cyc(input string tag);
    logic sel, ld;
    logic [3:0] mk;
    @(posedge clk);
    for (int i = 0; i < 4; i++)
      if (p_mask[i]) ref_mem[p_addr][i*9 +: 9] = p_din[i*9 +: 9];
    e_vld = p_rd;
    if (p_rd) e_data = ref_mem[p_addr];
    sel = !ce_n && cs_hi && !cs_lo_n;
    ld  = !strb_ctl_n || (!strb_cpu_n && !ce_n);
    if (ld) begin
      m_base = addr; m_cnt = 2'd0; m_act = sel;
    end else if (!adv_n && m_act) begin
      m_cnt = m_cnt + 2'd1;
    end
    mk = m_act ? lane_mask(gw_n, bwgate_n, bwb_n) : 4'h0;
    p_mask = mk;
    p_rd   = m_act && (lane_mask(gw_n, bwgate_n, bwb_n) == 4'h0);
    p_addr = eff_addr(m_base, m_cnt, order_il);
    p_din  = din;
    @(negedge clk);
    checks++;
    if (dout_vld !== (e_vld && !oe_n)) begin
      errors++;
      $display("FAIL %s: dout_vld=%0b expected %0b", tag, dout_vld, e_vld && !oe_n);
    end
    if (e_vld && !oe_n) begin
      checks++;
      if (dout !== e_data) begin
        errors++;
        $display("FAIL %s: dout=%h expected %h", tag, dout, e_data);
      end
    end
  endtask

  task automatic load(input logic [AW-1:0] a);
    idle(); strb_ctl_n = 0; addr = a;
  endtask

  // Deselecting load so the burst order may be changed safely.
  task automatic desel_set_order(input logic il);
    idle(); strb_ctl_n = 0; cs_hi = 0; addr = '0;
    cyc("R8");
    order_il = il;
    idle(); cyc("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11: watchdog expired, actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_base = '0; m_cnt = 2'd0; m_act = 0;
    p_mask = 4'h0; p_rd = 0; p_addr = '0; p_din = '0;
    e_vld = 0; e_data = '0;
    addr = '0; din = '0; order_il = 0;
    idle();
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout_vld !== 1'b0) begin
      errors++; $display("FAIL R11: dout_vld=%0b expected 0 in reset", dout_vld);
    end
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc("R11");

    // Fill every word with global-write bursts; lanes enables set against it (R6).
    for (int a = 0; a < DEPTH; a += 4) begin
      load(a[AW-1:0]); gw_n = 0; bwgate_n = 0; bwb_n = 4'hF; din = {$urandom, 4'h0};
      cyc("R6");
      for (int s = 0; s < 3; s++) begin
        idle(); adv_n = 0; gw_n = 0; din = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
        cyc("R6");
      end
    end
    idle(); cyc("R10"); cyc("R9");

    // Linear burst from offset 2: 6,7,4,5 (R4) with read latency (R9)
    load(6'd6); cyc("R9");
    for (int s = 0; s < 3; s++) begin idle(); adv_n = 0; cyc("R4"); end
    idle(); cyc("R4");

    // Interleaved burst from offset 1: 9,8,11,10 (R5)
    desel_set_order(1);
    load(6'd9); cyc("R5");
    for (int s = 0; s < 3; s++) begin idle(); adv_n = 0; cyc("R5"); end
    desel_set_order(0);

    // Advance held high repeats the address (R3)
    load(6'd20); cyc("R3");
    idle(); cyc("R3"); cyc("R3");
    idle(); adv_n = 0; cyc("R3");

    // Processor strobe honoured with enable, ignored without (R1)
    idle(); strb_cpu_n = 0; addr = 6'd33; cyc("R1");
    idle(); strb_cpu_n = 0; ce_n = 1; addr = 6'd40; adv_n = 0; cyc("R1");
    idle(); cyc("R1");

    // Both strobes with advance: load wins (R2)
    idle(); strb_ctl_n = 0; strb_cpu_n = 0; adv_n = 0; addr = 6'd50; cyc("R2");
    idle(); cyc("R2");

    // Lanes 0 and 2 written, then gate high blocks lane enables (R7)
    load(6'd12); gw_n = 1; bwgate_n = 0; bwb_n = 4'b1010; din = 36'hA_5A5A_5A5A; cyc("R7");
    idle(); cyc("R7");
    idle(); bwgate_n = 1; bwb_n = 4'h0; din = 36'h0_0000_0000; cyc("R7");
    idle(); cyc("R7"); cyc("R7");

    // Deselected load ignores writes and yields no valid reads (R8)
    load(6'd12); cs_lo_n = 1; gw_n = 0; din = 36'hF_0F0F_0F0F; cyc("R8");
    idle(); gw_n = 0; adv_n = 0; cyc("R8");
    idle(); cyc("R8");
    load(6'd12); cyc("R8");
    idle(); cyc("R8");

    // Output enable and write cycles mask the valid flag (R10)
    load(6'd30); cyc("R10");
    idle(); oe_n = 1; cyc("R10");
    idle(); gw_n = 0; din = 36'h1_2345_6789; cyc("R10");
    idle(); cyc("R10"); cyc("R10");

    // Random traffic under both burst orders
    for (int ph = 0; ph < 2; ph++) begin
      desel_set_order(ph[0]);
      for (int n = 0; n < 3000; n++) begin
        idle();
        addr       = $urandom_range(DEPTH-1, 0);
        strb_ctl_n = ($urandom_range(3, 0) != 0);
        strb_cpu_n = ($urandom_range(3, 0) != 0);
        ce_n       = ($urandom_range(7, 0) == 0);
        cs_hi      = ($urandom_range(11, 0) != 0);
        cs_lo_n    = ($urandom_range(11, 0) == 0);
        adv_n      = $urandom_range(1, 0);
        gw_n       = ($urandom_range(7, 0) != 0);
        bwgate_n   = ($urandom_range(2, 0) != 0);
        bwb_n      = $urandom_range(15, 0);
        oe_n       = ($urandom_range(7, 0) == 0);
        din        = {$urandom_range(15, 0), $urandom};
        if (ph == 0) cyc("R7"); else cyc("R5");
      end
    end

    done = 1;
    report();
    $finish;
  end
endmodule